// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing logic of a small byte-wide nonvolatile store of 128 locations, with the storage modelled as a register array. It listens on a two-wire serial bus (a clock line and an open-drain data line), recognises start and stop conditions, and answers only when the device-address byte names it through three strap inputs. Up to eight copies can therefore share one bus. A seven-bit word counter selects the location. The counter is set by an address byte and steps on every data byte, so both single-byte and four-byte page writes work, as do current-address, random and sequential reads.

Written bytes collect in a four-slot page buffer and are copied into the array when the stop condition arrives. A programming interval of a fixed number of system clocks then follows. During that interval the slave ignores the bus, so a master learns that the write has finished by sending device addresses until one is acknowledged. A write-lock input lets a board forbid all changes: locked writes are still acknowledged but have no effect. Both bus lines are sampled through synchronisers on a system clock that runs much faster than the bus clock.

Top module: `eeprom2w_slave`

## Requirements
- R1: A falling data line while the clock line is high (start) begins a new device-address byte from any state and drops any buffered write bytes. A rising data line while the clock line is high (stop) returns the slave to idle.
- R2: The device byte is, MSB first: bits 7..4 = 4'b1010, bits 3..1 = strap inputs, bit 0 = direction (1 read, 0 write). Only on a match does the slave pull the data line low during the ninth clock. On a mismatch it leaves the line released until the next start.
- R3: In a write, the byte after the device byte loads its low seven bits into the word counter, and the slave acknowledges it.
- R4: Each data byte of a write is acknowledged and reaches the array at the counter's location once the stop arrives.
- R5: Data bytes fill the aligned four-byte page that holds the loaded address. Only the low two address bits advance and wrap, so a fifth byte overwrites the first slot used. Other pages stay unchanged.
- R6: A stop that ends a write holding at least one data byte starts a busy interval of PROG_CYCLES system clocks. During it, device bytes are not acknowledged. Afterwards they are.
- R7: With the write lock high at the stop, the bytes are still acknowledged, the array keeps its contents and no busy interval starts.
- R8: A read sends the byte at the word counter, MSB first, and steps the counter by one for each byte sent.
- R9: A write of only an address, followed by a repeated start and a read device byte, returns the byte at that address.
- R10: While the master acknowledges, reading continues with the next address. The address wraps from 127 to 0.
- R11: A read byte that the master does not acknowledge ends the transfer. The data line is released and the next transaction is served normally.
- R12: After reset the data line is released, the word counter is 0 and every location reads 0.
- R13: A write carrying no data byte starts no busy interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClkIn | input | 1 | Bus clock line as seen at the pin |
| serDataIn | input | 1 | Bus data line as seen at the pin (wired level) |
| strapIn | input | 3 | Board-set device select bits |
| wrLock | input | 1 | High blocks every change to the array |
| serDataOe | output | 1 | High pulls the data line low (open drain) |

## Verification
Every bus-side result follows an edge of the bus clock by a fixed delay: two synchroniser stages, one edge-detect register and the control register, plus one more for the read shift register. An acknowledge or read bit therefore appears about five system clocks after the falling edge that precedes it. The bench changes the data line only in the middle of the clock-low phase and samples the wired line in the middle of the clock-high phase, at least ten system clocks after any change. The array contents count as due only once the busy interval has ended. The bench therefore checks that the first poll after a stop goes unacknowledged, polls until the slave answers, and only then reads the array back.

// File: rtl/e2w_pkg.sv
package e2w_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } ctlState_e;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic shiftIn;    // take inBit into the receive register
    logic inBit;
    logic loadAddr;   // receive register -> word counter
    logic pushData;   // receive register -> page slot
    logic loadTx;     // array -> transmit register, counter + 1
    logic shiftTx;    // next transmit bit
    logic clearPage;  // drop buffered bytes
    logic commit;     // stop after a write phase
  } dpStrobe_t;
endpackage

// File: rtl/e2w_ctrl.sv
module e2w_ctrl
  import e2w_pkg::*;
#(
  parameter int STRAP_W     = 3,
  parameter int DEV_TYPE    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serClkIn,
  input  logic               serDataIn,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic [BYTE_W-1:0]  rxByte,
  input  logic               txBit,
  input  logic               busy,
  output dpStrobe_t          strobe,
  output logic               serDataOe
);
  localparam int TYPE_W = BYTE_W - 1 - STRAP_W;
  localparam logic [3:0] ACK_CNT = 4'd8;
  localparam logic [3:0] END_CNT = 4'd9;

  logic [SYNC_STAGES-1:0] clkPipe, datPipe;
  logic clkS, datS, clkPrev, datPrev;
  logic riseEv, fallEv, startEv, stopEv;

  ctlState_e state, afterAck;
  logic [3:0] bitCnt;
  logic ackOn, txOn, mAck, devMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '1;
      datPipe <= '1;
      clkPrev <= 1'b1;
      datPrev <= 1'b1;
    end else begin
      clkPipe <= {clkPipe[SYNC_STAGES-2:0], serClkIn};
      datPipe <= {datPipe[SYNC_STAGES-2:0], serDataIn};
      clkPrev <= clkS;
      datPrev <= datS;
    end
  end

  assign clkS    = clkPipe[SYNC_STAGES-1];
  assign datS    = datPipe[SYNC_STAGES-1];
  assign riseEv  = clkS & ~clkPrev;
  assign fallEv  = ~clkS & clkPrev;
  assign startEv = clkS & clkPrev & datPrev & ~datS;
  assign stopEv  = clkS & clkPrev & ~datPrev & datS;

  assign devMatch = (rxByte[BYTE_W-1:STRAP_W+1] == TYPE_W'(DEV_TYPE)) &&
                    (rxByte[STRAP_W:1] == strapIn);

  // strobes to datapath
  always_comb begin
    strobe       = '0;
    strobe.inBit = datS;
    if (startEv) begin
      strobe.clearPage = 1'b1;
    end else if (stopEv) begin
      strobe.commit = (state == ST_WDATA);
    end else begin
      unique case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          strobe.shiftIn  = riseEv && (bitCnt < ACK_CNT);
          strobe.loadAddr = fallEv && (bitCnt == ACK_CNT) && (state == ST_WADDR);
          strobe.pushData = fallEv && (bitCnt == ACK_CNT) && (state == ST_WDATA);
          strobe.loadTx   = fallEv && (bitCnt == END_CNT) && (afterAck == ST_RDATA);
        end
        ST_RDATA: begin
          strobe.shiftTx = fallEv && (bitCnt != 4'd0) && (bitCnt < ACK_CNT);
          strobe.loadTx  = fallEv && (bitCnt == END_CNT) && mAck;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= ST_IDLE;
      bitCnt   <= '0;
      ackOn    <= 1'b0;
      txOn     <= 1'b0;
      mAck     <= 1'b0;
    end else if (startEv) begin
      state  <= busy ? ST_IDLE : ST_DEV;
      bitCnt <= '0;
      ackOn  <= 1'b0;
      txOn   <= 1'b0;
    end else if (stopEv) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      ackOn  <= 1'b0;
      txOn   <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (riseEv && bitCnt != END_CNT) begin
        bitCnt <= bitCnt + 4'd1;
        if (state == ST_RDATA && bitCnt == ACK_CNT) mAck <= ~datS;
      end
      if (state == ST_RDATA) begin
        if (fallEv && bitCnt == ACK_CNT) txOn <= 1'b0;
        if (fallEv && bitCnt == END_CNT) begin
          bitCnt <= '0;
          if (mAck) txOn  <= 1'b1;
          else      state <= ST_IDLE;
        end
      end else begin
        if (fallEv && bitCnt == ACK_CNT) begin
          unique case (state)
            ST_DEV: begin
              if (devMatch) begin
                ackOn    <= 1'b1;
                afterAck <= rxByte[0] ? ST_RDATA : ST_WADDR;
              end else begin
                state <= ST_IDLE;
              end
            end
            default: begin
              ackOn    <= 1'b1;
              afterAck <= ST_WDATA;
            end
          endcase
        end
        if (fallEv && bitCnt == END_CNT) begin
          ackOn  <= 1'b0;
          bitCnt <= '0;
          state  <= afterAck;
          if (afterAck == ST_RDATA) txOn <= 1'b1;
        end
      end
    end
  end

  assign serDataOe = ackOn | ((state == ST_RDATA) & txOn & ~txBit);

  // R1: a stop always leaves the slave idle
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (state == ST_IDLE));
  // R2: an idle slave never pulls the line
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !serDataOe);
  // R2: acknowledge only in the ninth clock slot
  p_ack_ninth_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackOn |-> (bitCnt >= ACK_CNT));
  // R6: while programming the slave stays off the bus
  p_busy_deaf_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state == ST_IDLE) |=> (state == ST_IDLE));
endmodule

// File: rtl/e2w_data.sv
module e2w_data
  import e2w_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int PAGE_W      = 2,
  parameter int PROG_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              wrLock,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic              busy
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PAGE_LEN = 1 << PAGE_W;
  localparam int BUSY_W   = $clog2(PROG_CYCLES + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] pageBuf [PAGE_LEN];
  logic [PAGE_LEN-1:0] pageValid;
  logic [ADDR_W-1:0] addrCnt;
  logic [BYTE_W-1:0] rxReg, txReg;
  logic [BUSY_W-1:0] busyCnt;
  logic commitOk;

  assign commitOk = strobe.commit && !wrLock && (|pageValid);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg   <= '0;
      txReg   <= '0;
      addrCnt <= '0;
    end else begin
      if (strobe.shiftIn) rxReg <= {rxReg[BYTE_W-2:0], strobe.inBit};
      if (strobe.loadAddr) addrCnt <= rxReg[ADDR_W-1:0];
      if (strobe.pushData)
        addrCnt[PAGE_W-1:0] <= addrCnt[PAGE_W-1:0] + PAGE_W'(1);
      if (strobe.loadTx) begin
        txReg   <= mem[addrCnt];
        addrCnt <= addrCnt + ADDR_W'(1);
      end else if (strobe.shiftTx) begin
        txReg <= {txReg[BYTE_W-2:0], 1'b0};
      end
    end
  end

  // one register slot per page position
  for (genvar g = 0; g < PAGE_LEN; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageBuf[g]   <= '0;
        pageValid[g] <= 1'b0;
      end else if (strobe.clearPage || strobe.commit) begin
        pageValid[g] <= 1'b0;
      end else if (strobe.pushData && addrCnt[PAGE_W-1:0] == PAGE_W'(g)) begin
        pageBuf[g]   <= rxReg;
        pageValid[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commitOk) begin
      for (int s = 0; s < PAGE_LEN; s++)
        if (pageValid[s]) mem[{addrCnt[ADDR_W-1:PAGE_W], PAGE_W'(s)}] <= pageBuf[s];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busyCnt <= '0;
    else if (commitOk)        busyCnt <= BUSY_W'(PROG_CYCLES);
    else if (busyCnt != '0)   busyCnt <= busyCnt - BUSY_W'(1);
  end

  assign busy   = (busyCnt != '0);
  assign rxByte = rxReg;
  assign txBit  = txReg[BYTE_W-1];

  // R5: page pushes never leave the page
  p_page_stay_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushData |=> (addrCnt[ADDR_W-1:PAGE_W] == $past(addrCnt[ADDR_W-1:PAGE_W])));
  // R6: an unlocked stop with data starts programming
  p_commit_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !wrLock && (|pageValid)) |=> busy);
  // R7: programming never starts under the lock
  p_lock_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(wrLock));
endmodule

// File: rtl/eeprom2w_slave.sv
module eeprom2w_slave
  import e2w_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int PAGE_W      = 2,
  parameter int STRAP_W     = 3,
  parameter int DEV_TYPE    = 10,
  parameter int SYNC_STAGES = 2,
  parameter int PROG_CYCLES = 2000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serClkIn,
  input  logic               serDataIn,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic               wrLock,
  output logic               serDataOe
);
  dpStrobe_t strobe;
  logic [BYTE_W-1:0] rxByte;
  logic txBit, busy;

  e2w_ctrl #(
    .STRAP_W(STRAP_W), .DEV_TYPE(DEV_TYPE), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .serClkIn(serClkIn), .serDataIn(serDataIn),
    .strapIn(strapIn), .rxByte(rxByte), .txBit(txBit), .busy(busy),
    .strobe(strobe), .serDataOe(serDataOe)
  );

  e2w_data #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrLock(wrLock),
    .rxByte(rxByte), .txBit(txBit), .busy(busy)
  );
endmodule

// File: tb/tb_eeprom2w_slave.sv
`timescale 1ns/1ps
module tb_eeprom2w_slave;
  localparam int Q = 10;
  localparam int H = 20;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};
  // {op, addr[6:0], data}: op 1 = byte write, op 0 = random read expecting data
  localparam logic [15:0] VEC [8] = '{
    {1'b1, 7'h05, 8'h3C}, {1'b1, 7'h7F, 8'hA5}, {1'b1, 7'h00, 8'h5A},
    {1'b1, 7'h01, 8'hC3}, {1'b0, 7'h05, 8'h3C}, {1'b0, 7'h7F, 8'hA5},
    {1'b0, 7'h01, 8'hC3}, {1'b0, 7'h30, 8'h00}
  };

  logic clk = 1'b0, rstN = 1'b0, mScl = 1'b1, mSda = 1'b1, wrLock = 1'b0;
  logic serDataOe;
  wire  busLine = mSda & ~serDataOe;
  int   checks = 0, failures = 0, cycles = 0;

  always #5 clk = ~clk;

  eeprom2w_slave dut (
    .clk(clk), .rstN(rstN), .serClkIn(mScl), .serDataIn(busLine),
    .strapIn(STRAP), .wrLock(wrLock), .serDataOe(serDataOe)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic startCond();
    mSda = 1'b1; waitClk(Q); mScl = 1'b1; waitClk(Q);
    mSda = 1'b0; waitClk(Q); mScl = 1'b0; waitClk(Q);
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitClk(Q); mScl = 1'b1; waitClk(Q); mSda = 1'b1; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitClk(Q); mScl = 1'b1; waitClk(H); mScl = 1'b0; waitClk(Q);
    end
    mSda = 1'b1; waitClk(Q); mScl = 1'b1; waitClk(H/2);
    ack = ~busLine; waitClk(H/2); mScl = 1'b0; waitClk(Q);
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(Q); mScl = 1'b1; waitClk(H/2); b[i] = busLine;
      waitClk(H/2); mScl = 1'b0; waitClk(Q);
    end
    mSda = ~giveAck; waitClk(Q); mScl = 1'b1; waitClk(H); mScl = 1'b0; waitClk(Q);
    mSda = 1'b1;
  endtask

  // count unanswered polls before the slave acknowledges again
  task automatic pollReady(output int polls);
    bit a;
    polls = 0;
    for (int k = 0; k < 40; k++) begin
      startCond(); sendByte(DEV_W, a); stopCond();
      if (a) break;
      polls++;
    end
  endtask

  task automatic byteWrite(input logic [6:0] a, input logic [7:0] d);
    bit k;
    startCond();
    sendByte(DEV_W, k); chk(k, "R2 device ack on write", k, 1);
    sendByte({1'b0, a}, k); chk(k, "R3 address ack", k, 1);
    sendByte(d, k); chk(k, "R4 data ack", k, 1);
    stopCond();
  endtask

  task automatic setAddr(input logic [6:0] a);
    bit k;
    startCond(); sendByte(DEV_W, k); sendByte({1'b0, a}, k);
    chk(k, "R9 dummy address ack", k, 1);
    startCond(); sendByte(DEV_R, k); chk(k, "R9 read device ack", k, 1);
  endtask

  initial begin
    bit k;
    int p;
    logic [7:0] d;
    logic [7:0] exp5 [5];
    waitClk(4); rstN = 1'b1; waitClk(10);
    chk(serDataOe == 1'b0, "R12 line released after reset", int'(serDataOe), 0);

    // R12 / R8: current address read after reset gives location 0 = 0
    startCond(); sendByte(DEV_R, k); chk(k, "R8 read device ack", k, 1);
    recvByte(1'b0, d); stopCond();
    chk(d == 8'h00, "R12 reset contents", d, 0);

    // R2: wrong strap is ignored
    startCond(); sendByte({4'b1010, 3'b010, 1'b0}, k); stopCond();
    chk(!k, "R2 mismatched strap no ack", k, 0);
    chk(serDataOe == 1'b0, "R2 line released on mismatch", int'(serDataOe), 0);

    // table of writes and random reads
    foreach (VEC[i]) begin
      if (VEC[i][15]) begin
        byteWrite(VEC[i][14:8], VEC[i][7:0]);
        pollReady(p);
        chk(p >= 1 && p < 40, "R6 busy after write then ready", p, 1);
      end else begin
        setAddr(VEC[i][14:8]); recvByte(1'b0, d); stopCond();
        chk(d == VEC[i][7:0], "R4 R9 readback", d, VEC[i][7:0]);
        chk(serDataOe == 1'b0, "R11 release after nack", int'(serDataOe), 0);
      end
    end

    // R10: sequential read across the top address
    setAddr(7'h7F);
    recvByte(1'b1, d); chk(d == 8'hA5, "R10 seq byte at 7F", d, 8'hA5);
    recvByte(1'b1, d); chk(d == 8'h5A, "R10 wrap to 00", d, 8'h5A);
    recvByte(1'b0, d); stopCond();
    chk(d == 8'hC3, "R10 then 01", d, 8'hC3);
    // R8: counter now at 02
    startCond(); sendByte(DEV_R, k); recvByte(1'b0, d); stopCond();
    chk(d == 8'h00, "R8 current address after sequence", d, 0);

    // R5: five bytes starting at 11 in page 10..13
    startCond(); sendByte(DEV_W, k); sendByte(8'h11, k);
    for (int i = 0; i < 5; i++) begin
      sendByte(8'hB0 + 8'(i), k);
      chk(k, "R5 page byte ack", k, 1);
    end
    stopCond(); pollReady(p);
    exp5 = '{8'hB3, 8'hB4, 8'hB1, 8'hB2, 8'h00};
    setAddr(7'h10);
    for (int i = 0; i < 5; i++) begin
      recvByte(i != 4, d);
      chk(d == exp5[i], "R5 page wrap contents", d, exp5[i]);
    end
    stopCond();

    // R7: locked write is acknowledged but has no effect
    wrLock = 1'b1;
    byteWrite(7'h05, 8'hFF);
    pollReady(p);
    chk(p == 0, "R7 no busy under lock", p, 0);
    wrLock = 1'b0;
    setAddr(7'h05); recvByte(1'b0, d); stopCond();
    chk(d == 8'h3C, "R7 contents kept", d, 8'h3C);

    // R13: address-only write
    startCond(); sendByte(DEV_W, k); sendByte(8'h22, k); stopCond();
    pollReady(p);
    chk(p == 0, "R13 no busy without data", p, 0);

    // R1: repeated start drops buffered bytes
    startCond(); sendByte(DEV_W, k); sendByte(8'h20, k); sendByte(8'h77, k);
    startCond(); sendByte(DEV_R, k);
    chk(k, "R1 repeated start restarts device byte", k, 1);
    recvByte(1'b0, d); stopCond();
    pollReady(p);
    chk(p == 0, "R1 dropped write starts no busy", p, 0);
    setAddr(7'h20); recvByte(1'b0, d); stopCond();
    chk(d == 8'h00, "R1 dropped byte not stored", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule